// File: doc/BRIEF.md
# Two-Way Doorbell Interrupt Unit

This block holds two doorbell registers that let a host-bus agent and a local processor signal each other. Each side has its own simple register port: a write strobe with a 2-bit address and data, and a combinational read path. The outbound doorbell is raised by the local processor and acknowledged by the host. The inbound doorbell is raised by the host and acknowledged by the local processor. Every doorbell bit is sticky: the side that raises it can only add bits, and only the opposite side can clear bits, one bit per written 1.

Each direction has its own mask register. The mask only gates the interrupt and never touches the stored doorbell bits. The outbound interrupt reaches the host in one of two forms. With message-signaled mode off it is an active-low level pin. With message-signaled mode on it is a single-cycle request pulse. The top inbound bit is set aside as an error doorbell. It has its own unmaskable interrupt output and takes no part in the normal inbound interrupt.

Top module: `dbell_bridge`

## Requirements
- R1: During and after reset both doorbells read 0 and both masks read all ones. `host_irq_n` is 1, and `host_msi_req`, `local_irq` and `local_err_irq` are 0.
- R2: A host write to address 1 ORs its data into the inbound doorbell. A local write to address 1 ORs its data into the outbound doorbell. The new value is visible after the next rising clock edge.
- R3: A write from the setting side never clears a doorbell bit. Bits written as 0 keep their value.
- R4: A host write to address 0 clears every outbound bit where the data is 1. A local write to address 0 does the same for the inbound doorbell. Bits written as 0 are left unchanged.
- R5: If a set and a clear hit the same bit in the same cycle, the bit ends up set.
- R6: A host write to address 2 loads the outbound mask, and a local write to address 2 loads the inbound mask. A mask bit of 1 suppresses the interrupt for that bit. Masks never change the stored doorbell bits. Address 2 reads the side's own mask.
- R7: `local_irq` is 1 exactly when some inbound bit other than bit 31 is set and its inbound mask bit is 0.
- R8: Inbound bit 31 is the error doorbell. `local_err_irq` equals that bit whatever the mask says, and bit 31 never drives `local_irq`.
- R9: The outbound condition is true when some outbound bit is set and its mask bit is 0. With `msi_en` = 0, `host_irq_n` is the inverse of that condition. With `msi_en` = 1, `host_irq_n` is held at 1.
- R10: With `msi_en` = 1, `host_msi_req` is 1 for exactly the one cycle in which the outbound condition is true and was false in the cycle before. It is 0 at all other times.
- R11: Address 0 on the host port reads the outbound doorbell, and address 1 reads the inbound doorbell. On the local port, address 0 reads the inbound doorbell and address 1 reads the outbound doorbell. Address 3 reads status. On the host port, status bit 0 is the outbound condition. On the local port, status bit 0 is `local_irq` and status bit 1 is `local_err_irq`. All other status bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_wr_en | input | 1 | Host write strobe |
| h_wr_addr | input | 2 | Host write address (0 clear outbound, 1 set inbound, 2 outbound mask) |
| h_wr_data | input | DW | Host write data |
| h_rd_addr | input | 2 | Host read address |
| h_rd_data | output | DW | Host read data |
| l_wr_en | input | 1 | Local write strobe |
| l_wr_addr | input | 2 | Local write address (0 clear inbound, 1 set outbound, 2 inbound mask) |
| l_wr_data | input | DW | Local write data |
| l_rd_addr | input | 2 | Local read address |
| l_rd_data | output | DW | Local read data |
| msi_en | input | 1 | Selects message-signaled outbound interrupt |
| host_irq_n | output | 1 | Active-low outbound level interrupt |
| host_msi_req | output | 1 | One-cycle message-signaled request |
| local_irq | output | 1 | Normal inbound interrupt |
| local_err_irq | output | 1 | Error doorbell interrupt |

## Verification
The assertions check four properties on every cycle. Bits written by the setting side are present on the next cycle. A written 1 from the clearing side removes the bit unless a set collides with it. The pin stays quiet in message-signaled mode and the request pulse never lasts two cycles. The error interrupt only rises after a host write with bit 31 set. The bench covers the behaviours that depend on a mix of state. Mask values decide the interrupts, mode switches happen while a condition is pending, the readback map and status bits are checked, and the error bit stays masked out of the normal interrupt. For these it runs directed sequences and a long random run against its own reference model.

// File: rtl/dbell_bridge.sv
module dbell_bridge #(
  parameter int DW      = 32,
  parameter int ERR_BIT = DW - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_wr_en,
  input  logic [1:0]    h_wr_addr,
  input  logic [DW-1:0] h_wr_data,
  input  logic [1:0]    h_rd_addr,
  output logic [DW-1:0] h_rd_data,
  input  logic          l_wr_en,
  input  logic [1:0]    l_wr_addr,
  input  logic [DW-1:0] l_wr_data,
  input  logic [1:0]    l_rd_addr,
  output logic [DW-1:0] l_rd_data,
  input  logic          msi_en,
  output logic          host_irq_n,
  output logic          host_msi_req,
  output logic          local_irq,
  output logic          local_err_irq
);

  localparam logic [DW-1:0] NORM_BITS = ~(DW'(1) << ERR_BIT);

  logic [DW-1:0] out_db, in_db, out_mask, in_mask;
  logic [DW-1:0] out_set, out_clr, in_set, in_clr;
  logic          out_pend, out_pend_q, in_pend, in_err;

  assign out_set = (l_wr_en && l_wr_addr == 2'd1) ? l_wr_data : '0;
  assign out_clr = (h_wr_en && h_wr_addr == 2'd0) ? h_wr_data : '0;
  assign in_set  = (h_wr_en && h_wr_addr == 2'd1) ? h_wr_data : '0;
  assign in_clr  = (l_wr_en && l_wr_addr == 2'd0) ? l_wr_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_db     <= '0;
      in_db      <= '0;
      out_mask   <= '1;
      in_mask    <= '1;
      out_pend_q <= 1'b0;
    end else begin
      out_db     <= (out_db & ~out_clr) | out_set;
      in_db      <= (in_db & ~in_clr) | in_set;
      out_pend_q <= out_pend;
      if (h_wr_en && h_wr_addr == 2'd2) out_mask <= h_wr_data;
      if (l_wr_en && l_wr_addr == 2'd2) in_mask  <= l_wr_data;
    end
  end

  assign out_pend = |(out_db & ~out_mask);
  assign in_pend  = |(in_db & ~in_mask & NORM_BITS);
  assign in_err   = in_db[ERR_BIT];

  assign host_irq_n    = ~(out_pend & ~msi_en);
  assign host_msi_req  = msi_en & out_pend & ~out_pend_q;
  assign local_irq     = in_pend;
  assign local_err_irq = in_err;

  always_comb begin
    case (h_rd_addr)
      2'd0:    h_rd_data = out_db;
      2'd1:    h_rd_data = in_db;
      2'd2:    h_rd_data = out_mask;
      default: h_rd_data = DW'(out_pend);
    endcase
    case (l_rd_addr)
      2'd0:    l_rd_data = in_db;
      2'd1:    l_rd_data = out_db;
      2'd2:    l_rd_data = in_mask;
      default: l_rd_data = DW'({in_err, in_pend});
    endcase
  end

endmodule

module dbell_bridge_chk #(
  parameter int DW      = 32,
  parameter int ERR_BIT = DW - 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          h_wr_en,
  input logic [1:0]    h_wr_addr,
  input logic [DW-1:0] h_wr_data,
  input logic          l_wr_en,
  input logic [1:0]    l_wr_addr,
  input logic [DW-1:0] l_wr_data,
  input logic          msi_en,
  input logic          host_irq_n,
  input logic          host_msi_req,
  input logic          local_err_irq,
  input logic [DW-1:0] out_db
);

  logic h_clr, l_set;
  assign h_clr = h_wr_en && h_wr_addr == 2'd0;
  assign l_set = l_wr_en && l_wr_addr == 2'd1;

  p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    l_set |=> ((out_db & $past(l_wr_data)) == $past(l_wr_data)));

  p_no_self_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !h_clr |=> ((out_db & $past(out_db)) == $past(out_db)));

  p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (h_clr && !l_set) |=> ((out_db & $past(h_wr_data)) == '0));

  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (h_clr && l_set) |=> ((out_db & $past(h_wr_data & l_wr_data)) == $past(h_wr_data & l_wr_data)));

  p_err_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(local_err_irq) |-> $past(h_wr_en && h_wr_addr == 2'd1 && h_wr_data[ERR_BIT]));

  p_pin_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    msi_en |-> host_irq_n);

  p_msi_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    host_msi_req |=> !host_msi_req);

endmodule

bind dbell_bridge dbell_bridge_chk #(.DW(DW), .ERR_BIT(ERR_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .h_wr_en(h_wr_en), .h_wr_addr(h_wr_addr), .h_wr_data(h_wr_data),
  .l_wr_en(l_wr_en), .l_wr_addr(l_wr_addr), .l_wr_data(l_wr_data),
  .msi_en(msi_en), .host_irq_n(host_irq_n), .host_msi_req(host_msi_req),
  .local_err_irq(local_err_irq), .out_db(out_db)
);

// File: tb/dbell_bridge_test.sv
`timescale 1ns/100ps
module dbell_bridge_test;
  localparam int DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic h_wr_en = 0, l_wr_en = 0, msi_en = 0;
  logic [1:0] h_wr_addr = 0, h_rd_addr = 0, l_wr_addr = 0, l_rd_addr = 0;
  logic [DW-1:0] h_wr_data = 0, l_wr_data = 0, h_rd_data, l_rd_data;
  logic host_irq_n, host_msi_req, local_irq, local_err_irq;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [DW-1:0] m_out = 0, m_in = 0, m_omask = '1, m_imask = '1;
  logic m_pq = 0;

  always #2.5 clk = ~clk;

  dbell_bridge #(.DW(DW)) uut (.*);

  function automatic logic f_opend(logic [DW-1:0] db, logic [DW-1:0] mk);
    return |(db & ~mk);
  endfunction
  function automatic logic f_ipend(logic [DW-1:0] db, logic [DW-1:0] mk);
    return |(db & ~mk & 32'h7fff_ffff);
  endfunction
  function automatic logic [DW-1:0] f_h_rd(logic [1:0] a);
    case (a)
      2'd0: return m_out;
      2'd1: return m_in;
      2'd2: return m_omask;
      default: return DW'(f_opend(m_out, m_omask));
    endcase
  endfunction
  function automatic logic [DW-1:0] f_l_rd(logic [1:0] a);
    case (a)
      2'd0: return m_in;
      2'd1: return m_out;
      2'd2: return m_imask;
      default: return DW'({m_in[31], f_ipend(m_in, m_imask)});
    endcase
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic p;
    p = f_opend(m_out, m_omask);
    chk("R9 host_irq_n", DW'(host_irq_n), DW'(!(p && !msi_en)));
    chk("R10 host_msi_req", DW'(host_msi_req), DW'(msi_en && p && !m_pq));
    chk("R7 local_irq", DW'(local_irq), DW'(f_ipend(m_in, m_imask)));
    chk("R8 local_err_irq", DW'(local_err_irq), DW'(m_in[31]));
    chk("R2 R3 R4 R5 R6 R11 host readback", h_rd_data, f_h_rd(h_rd_addr));
    chk("R2 R3 R4 R5 R6 R11 local readback", l_rd_data, f_l_rd(l_rd_addr));
  endtask

  task automatic step(logic hw, logic [1:0] ha, logic [DW-1:0] hd, logic [1:0] hr,
                      logic lw, logic [1:0] la, logic [DW-1:0] ld, logic [1:0] lr, logic me);
    logic [DW-1:0] os, oc, is, ic;
    @(negedge clk);
    h_wr_en = hw; h_wr_addr = ha; h_wr_data = hd; h_rd_addr = hr;
    l_wr_en = lw; l_wr_addr = la; l_wr_data = ld; l_rd_addr = lr; msi_en = me;
    @(posedge clk);
    os = (lw && la == 2'd1) ? ld : '0;
    oc = (hw && ha == 2'd0) ? hd : '0;
    is = (hw && ha == 2'd1) ? hd : '0;
    ic = (lw && la == 2'd0) ? ld : '0;
    m_pq  = f_opend(m_out, m_omask);
    m_out = (m_out & ~oc) | os;
    m_in  = (m_in & ~ic) | is;
    if (hw && ha == 2'd2) m_omask = hd;
    if (lw && la == 2'd2) m_imask = ld;
    #1 check_all();
  endtask

  initial begin
    #900000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    // R1: reset state, in reset and just after
    repeat (3) @(posedge clk);
    #1;
    chk("R1 host_irq_n", DW'(host_irq_n), DW'(1));
    chk("R1 local_irq", DW'(local_irq), '0);
    chk("R1 host_msi_req", DW'(host_msi_req), '0);
    @(negedge clk) rst_n = 1'b1;
    for (int a = 0; a < 4; a++) step(0, 0, 0, 2'(a), 0, 0, 0, 2'(a), 0);

    // R6: masked set is stored, no interrupt
    step(0, 0, 0, 0, 1, 1, 32'h0000_0005, 1, 0);
    // R3: setting side writes zeros, bits stay
    step(0, 0, 0, 0, 1, 1, 32'h0, 1, 0);
    // R9: unmask -> pin asserts
    step(1, 2, 32'h0, 0, 0, 0, 0, 2, 0);
    step(0, 0, 0, 3, 0, 0, 0, 1, 0);
    // R9: MSI mode quiets pin, no pulse since already pending
    step(0, 0, 0, 0, 0, 0, 0, 0, 1);
    // R4: host clears one bit, then the other
    step(1, 0, 32'h1, 0, 0, 0, 0, 1, 1);
    step(1, 0, 32'h4, 0, 0, 0, 0, 1, 1);
    // R10: rising condition in MSI mode -> one-cycle pulse
    step(0, 0, 0, 0, 1, 1, 32'h100, 1, 1);
    step(0, 0, 0, 0, 0, 0, 0, 1, 1);
    // R5: same-cycle set and clear on bit 8 -> set wins
    step(1, 0, 32'h100, 0, 1, 1, 32'h100, 1, 1);
    // R8: error bit while fully masked; R7 local_irq stays low
    step(1, 1, 32'h8000_0000, 1, 0, 0, 0, 3, 0);
    step(0, 0, 0, 1, 1, 2, 32'h0, 3, 0);
    // R7: normal inbound bit with mask open
    step(1, 1, 32'h0000_0002, 1, 0, 0, 0, 3, 0);
    // R4: local clears error bit only
    step(0, 0, 0, 1, 1, 0, 32'h8000_0000, 3, 0);
    step(0, 0, 0, 1, 1, 0, 32'h2, 3, 0);

    for (int i = 0; i < 4000; i++) begin
      logic [DW-1:0] hd, ld;
      hd = $urandom & $urandom & $urandom;
      ld = $urandom & $urandom & $urandom;
      if ($urandom_range(0, 3) == 0) hd = ld;
      step($urandom_range(0, 2) != 0, 2'($urandom), hd, 2'($urandom),
           $urandom_range(0, 2) != 0, 2'($urandom), ld, 2'($urandom),
           ($urandom_range(0, 7) < 3));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule